// File: doc/BRIEF.md
# Dual-Pair Carrier Waveform Generator

The block produces a square carrier wave whose high time and low time are each set in whole input clock cycles. Two register pairs hold the timing values, a primary pair and a secondary pair, each made of an 8-bit high count and an 8-bit low count. A narrow write port loads them. The registers are not cleared by reset, so a configuration survives a reset of the block.

In plain time mode the primary pair alone sets the waveform. In frequency-shift mode an external select input picks the pair. The select is sampled only when a new period begins, so a half-period already running is never cut short. A period-done strobe marks the last cycle of every low phase. A debug hold input freezes the counters in place, and counting resumes from the same point when the hold is released. A zero count is treated as a configuration fault. In that case the carrier stays low and an error flag is raised, so no malformed waveform is produced.

Top module: `cwg_top`

## Requirements
- R1: With nonzero counts HI and LO (1 to 255) in the active pair, the carrier repeats HI cycles high followed by LO cycles low.
- R2: On the first clock edge that samples run_en high with hold low and no fault, the carrier goes high in the cycle that follows that edge.
- R3: While fsk_en is low, pair 0 (the primary pair) sets every period, and pair_sel has no effect.
- R4: While fsk_en is high, pair_sel is sampled only at the edge that starts a high phase (0 = primary, 1 = secondary). A change during a period affects the next period only.
- R5: The four count registers keep their contents through reset.
- R6: If a count being loaded is zero (the high or low count of the chosen pair when a period starts, or the low count of the running pair when the low phase starts), the carrier goes low and cfg_err goes high. Both stay that way until run_en is deasserted.
- R7: While hold is high, the phase and the remaining count do not change, and period_done stays low. After release, the interrupted phase completes its remaining cycles.
- R8: period_done is high for exactly one cycle, the last cycle of each low phase, and never while the carrier is high.
- R9: Reset, or a clock edge that samples run_en low, leaves the carrier, period_done and cfg_err low after that edge.
- R10: A register write during a period takes effect at the next load of that register, not in the phase already running.
- R11: Write addresses: wr_addr bit 0 selects the low count (1) or the high count (0), and the upper bits select the pair. Address 0 is primary high, 1 is primary low, 2 is secondary high and 3 is secondary low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; counts are measured in its cycles |
| rst_n | input | 1 | Active-low synchronous reset of the control state |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (see R11) |
| wr_data | input | 8 | Count value to write |
| run_en | input | 1 | Generator enable |
| fsk_en | input | 1 | 1 = frequency-shift mode, 0 = time mode |
| pair_sel | input | 1 | Pair choice in frequency-shift mode |
| hold | input | 1 | Debug freeze of all counting |
| carrier | output | 1 | Carrier waveform |
| period_done | output | 1 | High in the last cycle of each low phase |
| cfg_err | output | 1 | Zero-count fault flag |

## Verification
The assertions assume that run_en, hold and pair_sel are synchronous to clk. They also assume that each register of a pair has been written before that pair is first selected, because the registers power up unknown and reset does not define them. The stimulus writes all four registers before the first enable. It changes every input half a cycle away from the rising edge, and it moves pair_sel only between writes of known values, either exactly at a period boundary or in the middle of a high phase, so each expected period can be computed ahead of time and queued.

// File: rtl/cwg_pkg.sv
package cwg_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_HIGH = 2'd1,
      PH_LOW  = 2'd2
   } phase_e;
endpackage

// File: rtl/cwg_regs.sv
module cwg_regs #(
   parameter  int CNT_W  = 8,
   parameter  int NPAIR  = 2,
   localparam int SEL_W  = $clog2(NPAIR),
   localparam int ADDR_W = SEL_W + 1
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [ADDR_W-1:0]                 wr_addr,
   input  logic [CNT_W-1:0]                  wr_data,
   output logic [NPAIR-1:0][CNT_W-1:0]       hi_all,
   output logic [NPAIR-1:0][CNT_W-1:0]       lo_all
);

   if (CNT_W < 2) begin : g_bad_width
      $error("cwg_regs: CNT_W must be at least 2");
   end
   if (NPAIR < 2 || (NPAIR & (NPAIR - 1)) != 0) begin : g_bad_pairs
      $error("cwg_regs: NPAIR must be a power of two, at least 2");
   end

   // One high and one low count per pair; no reset so contents survive it.
   for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      logic [CNT_W-1:0] hi_q;
      logic [CNT_W-1:0] lo_q;
      logic             pair_hit;

      assign pair_hit = wr_en && (wr_addr[ADDR_W-1:1] == SEL_W'(p));

      always_ff @(posedge clk) begin
         if (pair_hit && !wr_addr[0]) hi_q <= wr_data;
         if (pair_hit &&  wr_addr[0]) lo_q <= wr_data;
      end

      assign hi_all[p] = hi_q;
      assign lo_all[p] = lo_q;

      // R11: address bit 0 low writes the high count of pair p
      p_hi_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_addr == {SEL_W'(p), 1'b0}) |=> (hi_all[p] == $past(wr_data)));
      // R11: address bit 0 high writes the low count of pair p
      p_lo_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_addr == {SEL_W'(p), 1'b1}) |=> (lo_all[p] == $past(wr_data)));
   end

endmodule

// File: rtl/cwg_pairsel.sv
module cwg_pairsel #(
   parameter  int CNT_W = 8,
   parameter  int NPAIR = 2,
   localparam int SEL_W = $clog2(NPAIR)
) (
   input  logic                         fsk_en,
   input  logic [SEL_W-1:0]             pair_sel,
   input  logic [SEL_W-1:0]             run_pair,
   input  logic [NPAIR-1:0][CNT_W-1:0]  hi_all,
   input  logic [NPAIR-1:0][CNT_W-1:0]  lo_all,
   output logic [SEL_W-1:0]             next_pair,
   output logic [CNT_W-1:0]             start_hi,
   output logic                         start_bad,
   output logic [CNT_W-1:0]             run_lo
);

   // Time mode pins the choice to pair 0; frequency-shift mode follows the select.
   always_comb begin
      next_pair = fsk_en ? pair_sel : '0;
      start_hi  = hi_all[next_pair];
      start_bad = (hi_all[next_pair] == '0) || (lo_all[next_pair] == '0);
      run_lo    = lo_all[run_pair];
   end

endmodule

// File: rtl/cwg_core.sv
module cwg_core
   import cwg_pkg::*;
#(
   parameter  int CNT_W = 8,
   parameter  int NPAIR = 2,
   localparam int SEL_W = $clog2(NPAIR)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_en,
   input  logic              hold,
   input  logic [SEL_W-1:0]  next_pair,
   input  logic [CNT_W-1:0]  start_hi,
   input  logic              start_bad,
   input  logic [CNT_W-1:0]  run_lo,
   output logic [SEL_W-1:0]  run_pair,
   output logic              carrier,
   output logic              period_done,
   output logic              cfg_err
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   phase_e             phase_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [SEL_W-1:0]   pair_q;
   logic               err_q;
   logic               last_tick;
   logic               begin_ok;

   assign last_tick = (cnt_q == ONE);
   assign begin_ok  = !start_bad;

   always_ff @(posedge clk) begin
      if (!rst_n || !run_en) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         pair_q  <= '0;
         err_q   <= 1'b0;
      end else if (!hold) begin
         unique case (phase_q)
            PH_IDLE: begin
               if (!err_q) begin
                  if (begin_ok) begin
                     phase_q <= PH_HIGH;
                     cnt_q   <= start_hi;
                     pair_q  <= next_pair;
                  end else begin
                     err_q   <= 1'b1;
                  end
               end
            end
            PH_HIGH: begin
               if (!last_tick) begin
                  cnt_q <= cnt_q - ONE;
               end else if (run_lo != '0) begin
                  phase_q <= PH_LOW;
                  cnt_q   <= run_lo;
               end else begin
                  phase_q <= PH_IDLE;
                  cnt_q   <= '0;
                  err_q   <= 1'b1;
               end
            end
            PH_LOW: begin
               if (!last_tick) begin
                  cnt_q <= cnt_q - ONE;
               end else if (begin_ok) begin
                  phase_q <= PH_HIGH;
                  cnt_q   <= start_hi;
                  pair_q  <= next_pair;
               end else begin
                  phase_q <= PH_IDLE;
                  cnt_q   <= '0;
                  err_q   <= 1'b1;
               end
            end
            default: begin
               phase_q <= PH_IDLE;
               cnt_q   <= '0;
            end
         endcase
      end
   end

   assign run_pair    = pair_q;
   assign carrier     = (phase_q == PH_HIGH);
   assign period_done = run_en && !hold && (phase_q == PH_LOW) && last_tick;
   assign cfg_err     = err_q;

   // R7: a held generator keeps its phase and remaining count
   p_hold_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && hold) |=> (phase_q == $past(phase_q) && cnt_q == $past(cnt_q)));
   // R9: sampling run_en low leaves the generator idle and fault-free
   p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> (!carrier && !cfg_err && !period_done));
   // R6: a fault never coexists with a driven carrier
   p_err_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> !carrier);
   // R1: an active phase always has cycles left to run
   p_live_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q != PH_IDLE) |-> (cnt_q != '0));
   // R8: the strobe is followed by a new high phase or a fault
   p_done_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
      period_done |=> (carrier || cfg_err));
   // R2: a clean start drives the carrier high on the next cycle
   p_first_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && !hold && phase_q == PH_IDLE && !err_q && !start_bad) |=> carrier);

endmodule

// File: rtl/cwg_top.sv
module cwg_top #(
   parameter  int CNT_W  = 8,
   parameter  int NPAIR  = 2,
   localparam int SEL_W  = $clog2(NPAIR),
   localparam int ADDR_W = SEL_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic              run_en,
   input  logic              fsk_en,
   input  logic [SEL_W-1:0]  pair_sel,
   input  logic              hold,
   output logic              carrier,
   output logic              period_done,
   output logic              cfg_err
);

   logic [NPAIR-1:0][CNT_W-1:0] hi_all;
   logic [NPAIR-1:0][CNT_W-1:0] lo_all;
   logic [SEL_W-1:0]            next_pair;
   logic [SEL_W-1:0]            run_pair;
   logic [CNT_W-1:0]            start_hi;
   logic                        start_bad;
   logic [CNT_W-1:0]            run_lo;

   cwg_regs #(.CNT_W(CNT_W), .NPAIR(NPAIR)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .hi_all  (hi_all),
      .lo_all  (lo_all)
   );

   cwg_pairsel #(.CNT_W(CNT_W), .NPAIR(NPAIR)) u_sel (
      .fsk_en    (fsk_en),
      .pair_sel  (pair_sel),
      .run_pair  (run_pair),
      .hi_all    (hi_all),
      .lo_all    (lo_all),
      .next_pair (next_pair),
      .start_hi  (start_hi),
      .start_bad (start_bad),
      .run_lo    (run_lo)
   );

   cwg_core #(.CNT_W(CNT_W), .NPAIR(NPAIR)) u_core (
      .clk         (clk),
      .rst_n       (rst_n),
      .run_en      (run_en),
      .hold        (hold),
      .next_pair   (next_pair),
      .start_hi    (start_hi),
      .start_bad   (start_bad),
      .run_lo      (run_lo),
      .run_pair    (run_pair),
      .carrier     (carrier),
      .period_done (period_done),
      .cfg_err     (cfg_err)
   );

endmodule

// File: tb/tb_cwg_top.sv
`timescale 1ns/100ps
module tb_cwg_top;

   typedef struct {
      int    hi;
      int    lo;
      string tag;
   } per_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       run_en = 1'b0;
   logic       fsk_en = 1'b0;
   logic       pair_sel = 1'b0;
   logic       hold = 1'b0;
   logic       mon_clear = 1'b0;
   logic       carrier, period_done, cfg_err;

   int   n_chk = 0;
   int   n_fail = 0;
   bit   finished = 1'b0;
   int   hi_cnt = 0;
   int   lo_cnt = 0;
   per_t exp_q[$];
   per_t e;

   always #2.5 clk = ~clk;

   cwg_top dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .run_en(run_en), .fsk_en(fsk_en), .pair_sel(pair_sel), .hold(hold),
      .carrier(carrier), .period_done(period_done), .cfg_err(cfg_err)
   );

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic wreg(input logic [1:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      step();
      wr_en = 1'b0;
   endtask

   task automatic push(input int h, input int l, input string t);
      per_t x;
      x.hi = h; x.lo = l; x.tag = t;
      exp_q.push_back(x);
   endtask

   task automatic wait_done(input int n);
      for (int i = 0; i < n; i++) begin
         do @(negedge clk); while (!period_done);
      end
      #1;
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   // Monitor: measures each period and compares it with the queued expectation.
   always @(negedge clk) begin
      if (rst_n) begin
         if (mon_clear) begin
            hi_cnt = 0; lo_cnt = 0;
         end else if (!hold) begin
            if (carrier) begin
               if (period_done) check(1'b0, "R8 strobe while carrier high", 1, 0);
               hi_cnt++;
            end else if (hi_cnt > 0) begin
               lo_cnt++;
               if (period_done) begin
                  if (exp_q.size() == 0) begin
                     check(1'b0, "R1 unexpected period", 1, 0);
                  end else begin
                     e = exp_q.pop_front();
                     check(hi_cnt == e.hi, {e.tag, " high length"}, hi_cnt, e.hi);
                     check(lo_cnt == e.lo, {e.tag, " low length"}, lo_cnt, e.lo);
                  end
                  hi_cnt = 0; lo_cnt = 0;
               end
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         check(1'b0, "watchdog expired", 0, 1);
         summary();
         $finish;
      end
   end

   initial begin
      logic c0;
      step(); step();
      check(carrier == 1'b0, "R9 reset carrier", carrier, 0);
      check(period_done == 1'b0, "R9 reset period_done", period_done, 0);
      check(cfg_err == 1'b0, "R9 reset cfg_err", cfg_err, 0);
      rst_n = 1'b1;
      step();

      // R11: load all four registers through the address map
      wreg(2'd0, 8'd3); wreg(2'd1, 8'd2); wreg(2'd2, 8'd5); wreg(2'd3, 8'd4);

      // R3: time mode ignores pair_sel
      fsk_en = 1'b0; pair_sel = 1'b1;
      for (int i = 0; i < 3; i++) push(3, 2, "R3 time mode");
      run_en = 1'b1;
      step();
      check(carrier == 1'b1, "R2 first cycle high", carrier, 1);
      wait_done(3);

      // R4/R11: frequency-shift mode picks the secondary pair
      fsk_en = 1'b1; pair_sel = 1'b1;
      push(5, 4, "R11 secondary pair"); push(5, 4, "R4 secondary pair");
      wait_done(2);
      // R4: select change mid-period waits for the next period
      pair_sel = 1'b0;
      push(3, 2, "R4 primary pair"); push(5, 4, "R4 mid-period select");
      step(); step();
      pair_sel = 1'b1;
      wait_done(2);

      // R7: hold freezes in the middle of a high phase
      fsk_en = 1'b0;
      push(3, 2, "R7 held period"); push(3, 2, "R7 after hold");
      step(); step();
      hold = 1'b1;
      c0 = carrier;
      for (int i = 0; i < 4; i++) begin
         step();
         check(carrier == c0, "R7 carrier frozen", carrier, c0);
         check(period_done == 1'b0, "R7 no strobe while held", period_done, 0);
      end
      hold = 1'b0;
      wait_done(2);

      // R9: disable at a boundary
      run_en = 1'b0;
      step();
      check(carrier == 1'b0, "R9 disabled carrier", carrier, 0);

      // R10: writes during a period reach the next load only
      wreg(2'd0, 8'd5); wreg(2'd1, 8'd3);
      push(5, 6, "R10 low rewritten"); push(2, 6, "R10 high rewritten");
      run_en = 1'b1;
      step();
      wreg(2'd1, 8'd6); wreg(2'd0, 8'd2);
      wait_done(2);
      run_en = 1'b0;
      step();

      // R6: zero count produces a fault instead of a waveform
      wreg(2'd0, 8'd0);
      run_en = 1'b1;
      step();
      check(cfg_err == 1'b1, "R6 fault raised", cfg_err, 1);
      check(carrier == 1'b0, "R6 carrier low on fault", carrier, 0);
      for (int i = 0; i < 3; i++) begin
         step();
         check(cfg_err == 1'b1 && carrier == 1'b0, "R6 fault held", cfg_err, 1);
      end
      run_en = 1'b0;
      step();
      check(cfg_err == 1'b0, "R9 fault cleared by disable", cfg_err, 0);

      // R5: register contents survive reset
      wreg(2'd0, 8'd4); wreg(2'd1, 8'd3);
      rst_n = 1'b0;
      step();
      check(carrier == 1'b0 && cfg_err == 1'b0, "R9 reset mid-run outputs", carrier, 0);
      rst_n = 1'b1;
      step();
      push(4, 3, "R5 kept after reset"); push(4, 3, "R5 kept after reset");
      run_en = 1'b1;
      wait_done(2);

      // R9: disable in the middle of a high phase
      step();
      mon_clear = 1'b1;
      run_en = 1'b0;
      step();
      check(carrier == 1'b0, "R9 disable mid-high", carrier, 0);
      mon_clear = 1'b0;
      step();

      check(exp_q.size() == 0, "R1 all queued periods seen", exp_q.size(), 0);
      finished = 1'b1;
      summary();
      $finish;
   end

endmodule